// File: doc/BRIEF.md
# Resource Threshold Event Generator

This block watches three buffer occupancy counts (a descriptor count, a total count and a per-pool count), compares each against its own programmed threshold, and posts an event when a count climbs to or past its threshold. Events go out through a valid/ready handshake to a receive-queue event consumer. Each event carries a 2-bit code naming its source.

Software controls the block through three per-source arm bits, a global event-interface enable and a one-shot mode. In one-shot mode the block posts a single event for a source and then pulses a clear strobe back to the register file for that source's arm bit. No further events come from that source until software arms it again. Crossings that happen while a source is disarmed are lost; they are never replayed.

The block only detects edges, holds pending events and orders them. What the counts mean, and the registers themselves, belong to the surrounding logic.

Top module: `rthr_event_gen`

## Requirements
- R1: A source produces one event for each rising transition of the condition "count >= threshold" (unsigned compare). While that condition stays true, no further events come from that source.
- R2: The event code is 2'b01 for the descriptor source, 2'b10 for the total source and 2'b11 for the pool source. A presented event never carries 2'b00. In `src_arm` and `arm_clr`, bit 0 is the descriptor source, bit 1 the total source and bit 2 the pool source.
- R3: When several sources have events pending, they are presented in fixed order: descriptor first, then total, then pool. Each is presented once.
- R4: Once `evt_valid` is high, it stays high and `evt_code` stays unchanged until a cycle with `evt_ready` high, as long as `evt_if_en` stays high.
- R5: While `evt_if_en` is low, no crossing is captured, pending and presented events are discarded, and `evt_valid` is low from the next clock edge on. Crossings that happened while it was low are not replayed when it is set again.
- R6: A crossing on a source whose `src_arm` bit is low produces no event.
- R7: With `limit_mode` high, accepting an event (`evt_valid` and `evt_ready` both high at a clock edge) raises the `arm_clr` bit of that event's source for exactly the one following cycle. `arm_clr` is at most one-hot.
- R8: With `limit_mode` high, a source yields at most one event per arming. This holds for crossings while its event waits for the handshake and for crossings while it is disarmed. Setting the arm bit again produces no event by itself; the next crossing after re-arming does.
- R9: With `limit_mode` low, `arm_clr` stays zero.
- R10: The timing of an event is fixed. If a crossing is set up on the inputs before clock edge k, `evt_valid` rises after edge k+1 and is still low after edge k.
- R11: During reset and right after it, `evt_valid` and `arm_clr` are low. Reset is asynchronous, active-low, and its release is synchronized internally over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_cnt | input | CNT_W | Descriptor occupancy count |
| total_cnt | input | CNT_W | Total occupancy count |
| pool_cnt | input | CNT_W | Per-pool occupancy count |
| desc_thr | input | CNT_W | Descriptor threshold |
| total_thr | input | CNT_W | Total threshold |
| pool_thr | input | CNT_W | Pool threshold |
| src_arm | input | 3 | Per-source arm bits (bit0 desc, bit1 total, bit2 pool) |
| evt_if_en | input | 1 | Global event-interface enable |
| limit_mode | input | 1 | One-shot mode |
| evt_valid | output | 1 | Event presented |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_code | output | 2 | Source code of the presented event |
| arm_clr | output | 3 | One-cycle strobes that clear arm bits |

## Verification
Every threshold value of a 4-bit build is swept for each source while its count ramps upward. Checking the cycle of the single event against the threshold separates a ">=" compare from ">" or "==", and separates edge detection from level detection. All non-empty sets of simultaneous crossings are applied, and the order of the codes that come out exposes a wrong priority or a lost event. Stalled handshakes, toggling of the global enable, a disarmed source, and one-shot runs with re-crossings during a stall and after re-arming each isolate one gating path.

// File: rtl/rthr_pkg.sv
package rthr_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_DESC  = 2'b01,
    SRC_TOTAL = 2'b10,
    SRC_POOL  = 2'b11
  } src_code_e;

  function automatic src_code_e idx_to_code(input logic [IDX_W-1:0] idx);
    return src_code_e'(idx + 2'd1);
  endfunction
endpackage

// File: rtl/rthr_rst_sync.sv
module rthr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rthr_edge_det.sv
module rthr_edge_det #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  output logic             rise
);
  logic hit;
  logic hit_q;

  always_comb begin
    hit = (cnt >= thr);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  assign rise = hit & ~hit_q;
endmodule

// File: rtl/rthr_pend_arb.sv
module rthr_pend_arb
  import rthr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             if_en,
  input  logic [NSRC-1:0]  capture,
  input  logic             take,
  output logic             pend_any,
  output logic [IDX_W-1:0] sel_idx,
  output logic [NSRC-1:0]  sel_mask
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic            found;

  // lowest index wins: descriptor, total, pool
  always_comb begin
    sel_mask = '0;
    sel_idx  = '0;
    found    = 1'b0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (pend_q[i] && !found) begin
        found       = 1'b1;
        sel_mask[i] = 1'b1;
        sel_idx     = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (if_en) pend_d = (pend_q & ~(take ? sel_mask : '0)) | capture;
    else       pend_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_any = |pend_q;
endmodule

// File: rtl/rthr_out_stage.sv
module rthr_out_stage
  import rthr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             if_en,
  input  logic             limit_mode,
  input  logic             evt_ready,
  input  logic             pend_any,
  input  logic [IDX_W-1:0] sel_idx,
  output logic             take,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [NSRC-1:0]  arm_clr
);
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q;
  logic             idx_en;
  logic             accept;
  logic [NSRC-1:0]  clr_q, clr_d;

  always_comb begin
    accept = vld_q & evt_ready;
    take   = if_en & pend_any & (~vld_q | evt_ready);
    idx_en = take;
    if (!if_en)      vld_d = 1'b0;
    else if (take)   vld_d = 1'b1;
    else if (accept) vld_d = 1'b0;
    else             vld_d = vld_q;
  end

  always_comb begin
    clr_d = '0;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (limit_mode && accept && (idx_q == IDX_W'(i))) clr_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      clr_q <= '0;
    end else begin
      vld_q <= vld_d;
      clr_q <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= sel_idx;
  end

  assign out_valid = vld_q;
  assign out_idx   = idx_q;
  assign arm_clr   = clr_q;
endmodule

// File: rtl/rthr_event_gen.sv
module rthr_event_gen
  import rthr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] desc_cnt,
  input  logic [CNT_W-1:0] total_cnt,
  input  logic [CNT_W-1:0] pool_cnt,
  input  logic [CNT_W-1:0] desc_thr,
  input  logic [CNT_W-1:0] total_thr,
  input  logic [CNT_W-1:0] pool_thr,
  input  logic [2:0]       src_arm,
  input  logic             evt_if_en,
  input  logic             limit_mode,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [1:0]       evt_code,
  output logic [2:0]       arm_clr
);
  logic             rst_i_n;
  logic [CNT_W-1:0] cnt_a [NSRC];
  logic [CNT_W-1:0] thr_a [NSRC];
  logic [NSRC-1:0]  rise;
  logic [NSRC-1:0]  blocked;
  logic [NSRC-1:0]  capture;
  logic [NSRC-1:0]  sel_mask;
  logic [NSRC-1:0]  clr_vec;
  logic             pend_any;
  logic             take;
  logic             out_valid;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] out_idx;

  assign cnt_a[0] = desc_cnt;
  assign cnt_a[1] = total_cnt;
  assign cnt_a[2] = pool_cnt;
  assign thr_a[0] = desc_thr;
  assign thr_a[1] = total_thr;
  assign thr_a[2] = pool_thr;

  rthr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rthr_edge_det #(.CNT_W(CNT_W)) u_edge (
      .clk    (clk),
      .rst_ni (rst_i_n),
      .cnt    (cnt_a[g]),
      .thr    (thr_a[g]),
      .rise   (rise[g])
    );
    // one-shot: a source whose event is in flight or being disarmed takes no new crossing
    assign blocked[g] = limit_mode &
                        ((out_valid & (out_idx == IDX_W'(g))) |
                         clr_vec[g] | (take & sel_mask[g]));
    assign capture[g] = rise[g] & src_arm[g] & evt_if_en & ~blocked[g];
  end

  rthr_pend_arb u_arb (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .if_en    (evt_if_en),
    .capture  (capture),
    .take     (take),
    .pend_any (pend_any),
    .sel_idx  (sel_idx),
    .sel_mask (sel_mask)
  );

  rthr_out_stage u_out (
    .clk        (clk),
    .rst_ni     (rst_i_n),
    .if_en      (evt_if_en),
    .limit_mode (limit_mode),
    .evt_ready  (evt_ready),
    .pend_any   (pend_any),
    .sel_idx    (sel_idx),
    .take       (take),
    .out_valid  (out_valid),
    .out_idx    (out_idx),
    .arm_clr    (clr_vec)
  );

  assign evt_valid = out_valid;
  assign evt_code  = out_valid ? idx_to_code(out_idx) : SRC_NONE;
  assign arm_clr   = clr_vec;
endmodule

// File: rtl/rthr_event_gen_chk.sv
module rthr_event_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_if_en,
  input logic       limit_mode,
  input logic       evt_valid,
  input logic       evt_ready,
  input logic [1:0] evt_code,
  input logic [2:0] arm_clr
);
  p_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code != 2'b00));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && evt_if_en) |=> (evt_valid && $stable(evt_code)));

  p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_if_en |=> !evt_valid);

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arm_clr));

  p_clr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_clr != 3'b000) |-> $past(evt_valid && evt_ready && limit_mode));

  p_nolimit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_clr != 3'b000) |-> $past(limit_mode));
endmodule

bind rthr_event_gen rthr_event_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_if_en  (evt_if_en),
  .limit_mode (limit_mode),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .evt_code   (evt_code),
  .arm_clr    (arm_clr)
);

// File: tb/rthr_event_gen_test.sv
module rthr_event_gen_test;
  localparam int W    = 4;
  localparam int MAXV = 15;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt [3];
  logic [W-1:0] thr [3];
  logic [2:0]   src_arm;
  logic         evt_if_en, limit_mode, evt_ready;
  logic         evt_valid;
  logic [1:0]   evt_code;
  logic [2:0]   arm_clr;
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 0;

  always #4 clk = ~clk;

  rthr_event_gen #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .desc_cnt(cnt[0]), .total_cnt(cnt[1]), .pool_cnt(cnt[2]),
    .desc_thr(thr[0]), .total_thr(thr[1]), .pool_thr(thr[2]),
    .src_arm(src_arm), .evt_if_en(evt_if_en), .limit_mode(limit_mode),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
    .arm_clr(arm_clr)
  );

  // advance one edge; the bench's register-file model obeys clear strobes
  task automatic tick();
    @(posedge clk);
    #2;
    src_arm = src_arm & ~arm_clr;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic zero_cnts();
    for (int s = 0; s < 3; s++) cnt[s] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; zero_cnts();
    for (int s = 0; s < 3; s++) thr[s] = W'(MAXV);
    src_arm = 3'b111; evt_if_en = 1'b1; limit_mode = 1'b0; evt_ready = 1'b1;
    repeat (3) tick();
    chk("R11 valid in reset", int'(evt_valid), 0);
    chk("R11 clr in reset", int'(arm_clr), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R11 valid after reset", int'(evt_valid), 0);
    chk("R11 clr after reset", int'(arm_clr), 0);

    // R1 R2 R10 R9: threshold sweep per source with rising count
    for (int s = 0; s < 3; s++) begin
      for (int t = 0; t <= MAXV; t++) begin
        zero_cnts();
        for (int k = 0; k < 3; k++) thr[k] = W'(MAXV);
        thr[s] = W'(t);
        repeat (4) tick();
        for (int c = 1; c <= MAXV; c++) begin
          cnt[s] = W'(c);
          tick();
          chk("R10 no event after first edge", int'(evt_valid), 0);
          tick();
          chk("R1 event on crossing only", int'(evt_valid), (c == t) ? 1 : 0);
          if (c == t) chk("R2 source code", int'(evt_code), s + 1);
          chk("R9 no clear outside one-shot", int'(arm_clr), 0);
        end
      end
    end

    // R3: every set of simultaneous crossings comes out in fixed order
    for (int k = 0; k < 3; k++) thr[k] = W'(5);
    for (int m = 1; m < 8; m++) begin
      zero_cnts();
      repeat (3) tick();
      for (int s = 0; s < 3; s++) if (m[s]) cnt[s] = W'(5);
      tick();
      for (int s = 0; s < 3; s++) begin
        if (m[s]) begin
          tick();
          chk("R3 valid in order", int'(evt_valid), 1);
          chk("R3 code in order", int'(evt_code), s + 1);
        end
      end
      tick();
      chk("R3 no extra event", int'(evt_valid), 0);
    end

    // R4: hold under stall
    zero_cnts(); repeat (3) tick();
    evt_ready = 1'b0;
    for (int s = 0; s < 3; s++) cnt[s] = W'(5);
    tick(); tick();
    chk("R4 presented", int'(evt_valid), 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 valid held", int'(evt_valid), 1);
      chk("R4 code held", int'(evt_code), 1);
    end
    evt_ready = 1'b1;
    tick(); chk("R4 next after accept", int'(evt_code), 2);
    tick(); chk("R4 last after accept", int'(evt_code), 3);
    tick(); chk("R4 drained", int'(evt_valid), 0);
    repeat (3) tick();
    chk("R1 steady level quiet", int'(evt_valid), 0);

    // R5: global enable flushes and blocks
    zero_cnts(); repeat (3) tick();
    evt_ready = 1'b0;
    cnt[0] = W'(5); tick(); tick();
    chk("R5 event before disable", int'(evt_valid), 1);
    evt_if_en = 1'b0; tick();
    chk("R5 flushed on disable", int'(evt_valid), 0);
    evt_if_en = 1'b1; repeat (3) tick();
    chk("R5 flushed not replayed", int'(evt_valid), 0);
    evt_if_en = 1'b0;
    cnt[1] = W'(5); tick(); tick();
    chk("R5 no capture while off", int'(evt_valid), 0);
    evt_if_en = 1'b1; tick(); tick();
    chk("R5 off crossing not replayed", int'(evt_valid), 0);
    evt_ready = 1'b1;

    // R6: disarmed source
    zero_cnts(); src_arm = 3'b101; repeat (3) tick();
    for (int s = 0; s < 3; s++) cnt[s] = W'(5);
    tick(); tick();
    chk("R6 first armed source", int'(evt_code), 1);
    tick();
    chk("R6 disarmed source skipped", int'(evt_code), 3);
    tick();
    chk("R6 nothing more", int'(evt_valid), 0);
    src_arm = 3'b111;

    // R7 R8: one-shot
    limit_mode = 1'b1;
    zero_cnts(); repeat (3) tick();
    cnt[0] = W'(5); tick(); tick();
    chk("R7 one-shot event", int'(evt_code), 1);
    chk("R7 no clear before accept", int'(arm_clr), 0);
    tick();
    chk("R7 clear strobe desc", int'(arm_clr), 1);
    tick();
    chk("R7 strobe one cycle", int'(arm_clr), 0);
    cnt[0] = '0; tick();
    cnt[0] = W'(5); tick(); tick(); tick();
    chk("R8 disarmed crossing dropped", int'(evt_valid), 0);
    src_arm[0] = 1'b1; tick(); tick();
    chk("R8 re-arm alone silent", int'(evt_valid), 0);
    cnt[0] = '0; tick();
    cnt[0] = W'(5); tick(); tick();
    chk("R8 re-armed fires", int'(evt_code), 1);
    tick();
    chk("R7 clear again", int'(arm_clr), 1);
    tick();
    // re-crossing while the event waits for the handshake
    evt_ready = 1'b0;
    cnt[1] = W'(5); tick(); tick();
    chk("R8 total presented", int'(evt_code), 2);
    cnt[1] = '0; tick();
    cnt[1] = W'(5); tick(); tick();
    evt_ready = 1'b1; tick();
    chk("R7 clear strobe total", int'(arm_clr), 2);
    chk("R8 accepted", int'(evt_valid), 0);
    tick(); tick();
    chk("R8 stalled re-crossing dropped", int'(evt_valid), 0);

    done = 1;
    report();
  end
endmodule